// File: doc/BRIEF.md
# Doorbell Command Mailbox Register Block

This block is the device-side register file of a command mailbox. A host reaches it through a 64-bit register port and reads or writes one 8-byte word per access. The block holds a capabilities word, a control word with the doorbell bit, a command word (opcode and payload length), a status word carrying a return code, a background-status word that always reads zero, and a payload area of parameterised size.

Ownership passes between the two sides through the doorbell. While the doorbell is clear, the host owns the command and payload registers. It fills them and then rings the doorbell. From that point the device firmware owns the block. It sees a one-cycle command-pending pulse and reads the opcode, input length and payload. It may overwrite payload words. It completes the command with a single done strobe, which posts the return code and the output length and clears the doorbell on the same edge. After that the device can change nothing until the next ring.

Host word addresses count 8-byte words. Word 0 sits at byte 0x00, word 1 at 0x08, word 2 at 0x10, word 3 at 0x18, and payload word i at byte 0x20 + 8*i (word 4 + i). The reset input is asynchronous and active low. Its release is synchronised inside the block, so the block leaves reset on the third rising clock edge after reset goes high.

Top module: `mbox_regblock`

## Requirements
- R1: During reset and after it is released, the doorbell, busy, cmd_pending, opcode, length and return code are all zero.
- R2: Word 0 returns the payload size log2 (parameter PAY_LOG2, at least 8) in bits 4:0. It returns the doorbell in bit 32 (control register at byte offset 0x04, bit 0). All other bits of word 0 read 0.
- R3: A host write to word 0 with bit 32 set while the doorbell is clear sets the doorbell at that edge. cmd_pending is 1 for exactly the following cycle.
- R4: While the doorbell is set, host writes to word 1, to the payload words, and to word 0 are ignored. A write to word 0 therefore cannot clear the doorbell.
- R5: Word 1 holds the opcode in bits 15:0 and the payload length in bits 36:16, and its other bits read 0. While the doorbell is clear a host write loads both fields. dev_opcode and dev_in_len show the same fields.
- R6: dev_done while the doorbell is set does three things on one edge: it loads dev_ret_code into word 2 bits 47:32, loads dev_out_len into the length field of word 1, and clears the doorbell. Word 2 reads 0 in all other bits.
- R7: A device payload write (dev_pay_we) is accepted only while the doorbell is set. dev_pay_rdata shows the payload word selected by dev_pay_idx.
- R8: While the doorbell is clear, dev_done and dev_pay_we change nothing in words 0, 1 or 2 or in the payload.
- R9: The host reads back the payload words it wrote while the doorbell was clear. Word 3, and every address beyond the payload area, reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host 8-byte word address |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data for host_addr (combinational) |
| busy | output | 1 | Doorbell state |
| cmd_pending | output | 1 | One-cycle pulse after the doorbell rises |
| dev_opcode | output | 16 | Current opcode |
| dev_in_len | output | 21 | Current payload length field |
| dev_pay_we | input | 1 | Device payload write strobe |
| dev_pay_idx | input | IDX_W | Device payload word index |
| dev_pay_wdata | input | 64 | Device payload write data |
| dev_pay_rdata | output | 64 | Payload word at dev_pay_idx |
| dev_done | input | 1 | Device completion strobe |
| dev_ret_code | input | 16 | Return code posted on completion |
| dev_out_len | input | 21 | Output length posted on completion |

## Verification
The bench targets writes that arrive from the side that does not own the doorbell. A host write of 0 to the control word while the doorbell is set must leave it set. Otherwise a lost command would be handed back to the host with stale results. Device payload writes and completion strobes while the doorbell is clear must not corrupt the host's freshly written command. The completion edge is checked for the return code, the output length and the doorbell changing together, since a design that cleared the doorbell first would let the host read stale results. The bench also checks that cmd_pending lasts exactly one cycle, and that addresses just past the payload area and the background word read zero rather than aliasing into the payload.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned WORD_W     = 64;
  localparam int unsigned OPC_W      = 16;
  localparam int unsigned LEN_W      = 21;
  localparam int unsigned RET_W      = 16;
  localparam int unsigned W_CAPCTRL  = 0;
  localparam int unsigned W_CMD      = 1;
  localparam int unsigned W_STAT     = 2;
  localparam int unsigned W_BGSTAT   = 3;
  localparam int unsigned W_PAYBASE  = 4;
  localparam int unsigned BELL_BIT   = 32;
  localparam int unsigned LEN_LSB    = 16;
  localparam int unsigned RET_LSB    = 32;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [OPC_W-1:0] opcode;
  } cmd_t;
endpackage

// File: rtl/mbox_bell.sv
module mbox_bell (
  input  logic clk,
  input  logic rst_n,
  input  logic host_ctrl_we,
  input  logic host_ring,
  input  logic dev_done,
  output logic bell,
  output logic pend,
  output logic done_ok
);
  logic bell_q, bell_d;
  logic pend_q, pend_d;
  logic ring_ok;

  always_comb begin
    ring_ok = !bell_q && host_ctrl_we && host_ring;
    done_ok = bell_q && dev_done;
    bell_d  = bell_q;
    if (ring_ok)      bell_d = 1'b1;
    else if (done_ok) bell_d = 1'b0;
    pend_d  = ring_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bell_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      bell_q <= bell_d;
      pend_q <= pend_d;
    end
  end

  assign bell = bell_q;
  assign pend = pend_q;

  p_pend_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> !pend_q);
  p_ring_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bell_q && host_ctrl_we && host_ring) |=> (bell_q && pend_q));
  p_hold_bell_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bell_q && !dev_done) |=> bell_q);
  p_done_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bell_q && dev_done) |=> !bell_q);
endmodule

// File: rtl/mbox_cmdstat.sv
module mbox_cmdstat
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bell,
  input  logic              host_cmd_we,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              done_ok,
  input  logic [RET_W-1:0]  ret_in,
  input  logic [LEN_W-1:0]  len_in,
  output cmd_t              cmd,
  output logic [RET_W-1:0]  ret
);
  cmd_t             cmd_q, cmd_d;
  logic [RET_W-1:0] ret_q, ret_d;
  logic             cmd_en, ret_en;

  always_comb begin
    cmd_en = (!bell && host_cmd_we) || done_ok;
    ret_en = done_ok;
    cmd_d  = cmd_q;
    ret_d  = ret_q;
    if (!bell && host_cmd_we) begin
      cmd_d.opcode = host_wdata[OPC_W-1:0];
      cmd_d.len    = host_wdata[LEN_LSB +: LEN_W];
    end
    if (done_ok) begin
      cmd_d.len = len_in;
      ret_d     = ret_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      ret_q <= '0;
    end else begin
      if (cmd_en) cmd_q <= cmd_d;
      if (ret_en) ret_q <= ret_d;
    end
  end

  assign cmd = cmd_q;
  assign ret = ret_q;

  p_cmd_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bell && !done_ok) |=> $stable(cmd_q));
  p_stat_only_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_ok |=> $stable(ret_q));
  p_post_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> (cmd_q.len == $past(len_in) && ret_q == $past(ret_in)));
endmodule

// File: rtl/mbox_payload.sv
module mbox_payload
  import mbox_pkg::*;
#(
  parameter int unsigned PAY_LOG2 = 8,
  localparam int unsigned WORDS   = 2 ** (PAY_LOG2 - 3),
  localparam int unsigned IDX_W   = PAY_LOG2 - 3
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bell,
  input  logic              host_we,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              dev_we,
  input  logic [IDX_W-1:0]  dev_idx,
  input  logic [WORD_W-1:0] dev_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic [WORD_W-1:0] dev_rdata
);
  logic [WORD_W-1:0] mem_q [WORDS];
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [WORD_W-1:0] wr_data;

  always_comb begin
    wr_en   = bell ? dev_we : host_we;
    wr_idx  = bell ? dev_idx : host_idx;
    wr_data = bell ? dev_wdata : host_wdata;
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IDX_W'(g)) mem_q[g] <= wr_data;
    end
  end

  assign host_rdata = mem_q[host_idx];
  assign dev_rdata  = mem_q[dev_idx];

  initial p_min_size_r2: assert (PAY_LOG2 >= 8 && PAY_LOG2 <= 20);

  p_dev_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bell && dev_we) |=> (mem_q[$past(dev_idx)] == $past(dev_wdata)));
endmodule

// File: rtl/mbox_regblock.sv
module mbox_regblock
  import mbox_pkg::*;
#(
  parameter int unsigned PAY_LOG2 = 8,
  localparam int unsigned WORDS   = 2 ** (PAY_LOG2 - 3),
  localparam int unsigned IDX_W   = PAY_LOG2 - 3,
  localparam int unsigned ADDR_W  = $clog2(W_PAYBASE + WORDS) + 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [63:0]       host_wdata,
  output logic [63:0]       host_rdata,
  output logic              busy,
  output logic              cmd_pending,
  output logic [15:0]       dev_opcode,
  output logic [20:0]       dev_in_len,
  input  logic              dev_pay_we,
  input  logic [IDX_W-1:0]  dev_pay_idx,
  input  logic [63:0]       dev_pay_wdata,
  output logic [63:0]       dev_pay_rdata,
  input  logic              dev_done,
  input  logic [15:0]       dev_ret_code,
  input  logic [20:0]       dev_out_len
);
  logic              rs_q1, rs_q2;
  logic              bell, done_ok;
  cmd_t              cmd;
  logic [RET_W-1:0]  ret;
  logic [ADDR_W-1:0] pay_off;
  logic              in_pay;
  logic [WORD_W-1:0] pay_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end

  always_comb begin
    pay_off = host_addr - ADDR_W'(W_PAYBASE);
    in_pay  = (host_addr >= ADDR_W'(W_PAYBASE)) && (pay_off < ADDR_W'(WORDS));
  end

  mbox_bell u_bell (
    .clk          (clk),
    .rst_n        (rs_q2),
    .host_ctrl_we (host_we && host_addr == ADDR_W'(W_CAPCTRL)),
    .host_ring    (host_wdata[BELL_BIT]),
    .dev_done     (dev_done),
    .bell         (bell),
    .pend         (cmd_pending),
    .done_ok      (done_ok)
  );

  mbox_cmdstat u_cmd (
    .clk         (clk),
    .rst_n       (rs_q2),
    .bell        (bell),
    .host_cmd_we (host_we && host_addr == ADDR_W'(W_CMD)),
    .host_wdata  (host_wdata),
    .done_ok     (done_ok),
    .ret_in      (dev_ret_code),
    .len_in      (dev_out_len),
    .cmd         (cmd),
    .ret         (ret)
  );

  mbox_payload #(.PAY_LOG2(PAY_LOG2)) u_pay (
    .clk        (clk),
    .rst_n      (rs_q2),
    .bell       (bell),
    .host_we    (host_we && in_pay),
    .host_idx   (pay_off[IDX_W-1:0]),
    .host_wdata (host_wdata),
    .dev_we     (dev_pay_we),
    .dev_idx    (dev_pay_idx),
    .dev_wdata  (dev_pay_wdata),
    .host_rdata (pay_rd),
    .dev_rdata  (dev_pay_rdata)
  );

  always_comb begin
    host_rdata = '0;
    if (host_addr == ADDR_W'(W_CAPCTRL)) begin
      host_rdata[4:0]      = 5'(PAY_LOG2);
      host_rdata[BELL_BIT] = bell;
    end else if (host_addr == ADDR_W'(W_CMD)) begin
      host_rdata[OPC_W-1:0]        = cmd.opcode;
      host_rdata[LEN_LSB +: LEN_W] = cmd.len;
    end else if (host_addr == ADDR_W'(W_STAT)) begin
      host_rdata[RET_LSB +: RET_W] = ret;
    end else if (in_pay) begin
      host_rdata = pay_rd;
    end
  end

  assign busy       = bell;
  assign dev_opcode = cmd.opcode;
  assign dev_in_len = cmd.len;

  p_pend_busy_r3: assert property (@(posedge clk) disable iff (!rs_q2)
    cmd_pending |-> (busy && !$past(busy)));
  p_reset_idle_r1: assert property (@(posedge clk)
    !rs_q2 |-> (!busy && !cmd_pending));
endmodule

// File: tb/mbox_regblock_test.sv
module mbox_regblock_test;
  localparam int unsigned PL = 8;
  localparam int unsigned PW = 2 ** (PL - 3);
  localparam int unsigned IW = PL - 3;
  localparam int unsigned AW = $clog2(4 + PW) + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          host_we;
  logic [AW-1:0] host_addr;
  logic [63:0]   host_wdata, host_rdata;
  logic          busy, cmd_pending;
  logic [15:0]   dev_opcode;
  logic [20:0]   dev_in_len;
  logic          dev_pay_we;
  logic [IW-1:0] dev_pay_idx;
  logic [63:0]   dev_pay_wdata, dev_pay_rdata;
  logic          dev_done;
  logic [15:0]   dev_ret_code;
  logic [20:0]   dev_out_len;

  always #2.5 clk = ~clk;

  mbox_regblock #(.PAY_LOG2(PL)) uut (.*);

  int   n_chk = 0, n_bad = 0;
  bit   m_db, m_ring;
  logic [15:0] m_op;
  logic [20:0] m_len;
  logic [15:0] m_ret;
  logic [63:0] m_pay [PW];
  bit          m_known [PW];
  bit          finished = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_word(int a);
    logic [63:0] v = '0;
    if (a == 0) begin v[4:0] = 5'(PL); v[32] = m_db; end
    else if (a == 1) begin v[15:0] = m_op; v[36:16] = m_len; end
    else if (a == 2) v[47:32] = m_ret;
    else if (a >= 4 && a < 4 + PW) v = m_pay[a-4];
    return v;
  endfunction

  task automatic idle();
    host_we = 0; dev_pay_we = 0; dev_done = 0;
  endtask

  task automatic finish_cycle();
    @(posedge clk); #1;
    check("R3 cmd_pending", 64'(cmd_pending), 64'(m_ring));
    check("R3 busy", 64'(busy), 64'(m_db));
    m_ring = 0;
    idle();
  endtask

  task automatic host_wr(int a, logic [63:0] d);
    @(negedge clk);
    host_we = 1; host_addr = AW'(a); host_wdata = d;
    if (!m_db) begin
      if (a == 0 && d[32]) begin m_db = 1; m_ring = 1; end
      else if (a == 1) begin m_op = d[15:0]; m_len = d[36:16]; end
      else if (a >= 4 && a < 4 + PW) begin m_pay[a-4] = d; m_known[a-4] = 1; end
    end
    finish_cycle();
  endtask

  task automatic dev_wr(int i, logic [63:0] d);
    @(negedge clk);
    dev_pay_we = 1; dev_pay_idx = IW'(i); dev_pay_wdata = d;
    if (m_db) begin m_pay[i] = d; m_known[i] = 1; end
    finish_cycle();
  endtask

  task automatic dev_fin(logic [15:0] rc, logic [20:0] ol);
    @(negedge clk);
    dev_done = 1; dev_ret_code = rc; dev_out_len = ol;
    if (m_db) begin m_ret = rc; m_len = ol; m_db = 0; end
    finish_cycle();
  endtask

  task automatic host_chk(string req, int a);
    @(negedge clk);
    host_addr = AW'(a); #1;
    if (a >= 4 && a < 4 + PW && !m_known[a-4]) return;
    check(req, host_rdata, exp_word(a));
  endtask

  initial begin
    #500000;
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240);
    idle(); host_addr = '0; host_wdata = '0; dev_pay_idx = '0;
    dev_pay_wdata = '0; dev_ret_code = '0; dev_out_len = '0;
    m_db = 0; m_ring = 0; m_op = 0; m_len = 0; m_ret = 0;
    for (int i = 0; i < PW; i++) begin m_pay[i] = '0; m_known[i] = 0; end
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 busy in reset", 64'(busy), 0);
    check("R1 pending in reset", 64'(cmd_pending), 0);
    rst_n = 1;
    repeat (4) @(posedge clk);
    host_chk("R1/R2 word0 after reset", 0);
    host_chk("R1 word1 after reset", 1);
    host_chk("R1 word2 after reset", 2);
    check("R5 dev_opcode reset", 64'(dev_opcode), 0);

    // R5 and R9: load command and payload while the doorbell is clear
    host_wr(1, 64'hFFFF_FFE1_2345_BEEF);
    host_chk("R5 command fields", 1);
    check("R5 dev_opcode", 64'(dev_opcode), 64'h0000_BEEF);
    check("R5 dev_in_len", 64'(dev_in_len), 64'(m_len));
    host_wr(4, 64'h0123_4567_89AB_CDEF);
    host_wr(4 + PW - 1, 64'hCAFE_F00D_0000_0001);
    host_chk("R9 first payload", 4);
    host_chk("R9 last payload", 4 + PW - 1);
    host_chk("R9 background word", 3);
    host_chk("R9 past payload", 4 + PW);
    host_chk("R9 top address", (1 << AW) - 1);

    // R8: device actions while idle
    dev_wr(0, 64'hDEAD_DEAD_DEAD_DEAD);
    dev_fin(16'h0055, 21'h1_0000);
    host_chk("R8 payload untouched", 4);
    host_chk("R8 word1 untouched", 1);
    host_chk("R8 word2 untouched", 2);

    // R3: ring
    host_wr(0, 64'h1_0000_0000);
    @(posedge clk); #1;
    check("R3 pending one cycle", 64'(cmd_pending), 0);
    host_chk("R2 doorbell bit", 0);

    // R4: host blocked while set
    host_wr(1, 64'h0000_0000_0000_1111);
    host_wr(5 - 1, 64'h5555_5555_5555_5555);
    host_wr(0, 64'h0);
    host_chk("R4 command frozen", 1);
    host_chk("R4 payload frozen", 4);
    check("R4 doorbell held", 64'(busy), 1);

    // R7, R6: device works and completes
    dev_wr(1, 64'h7777_0000_7777_0000);
    @(negedge clk); dev_pay_idx = 1; #1;
    check("R7 dev readback", dev_pay_rdata, 64'h7777_0000_7777_0000);
    dev_fin(16'h0000, 21'h00040);
    host_chk("R6 status ret", 2);
    host_chk("R6 out len", 1);
    host_chk("R7 payload via host", 5);
    dev_fin(16'h00AA, 21'h1F_FFFF);
    host_chk("R8 no re-post", 2);
    host_wr(0, 64'h1_0000_0000);
    dev_fin(16'hFFFF, 21'h1F_FFFF);
    host_chk("R6 max ret", 2);
    host_chk("R6 max len", 1);

    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      int unsigned k = $urandom_range(0, 99);
      int a = int'($urandom_range(0, 4 + PW + 1));
      logic [63:0] d = {$urandom(), $urandom()};
      if (k < 15)      host_wr(0, {31'h0, 1'($urandom_range(0, 1)), 32'h0});
      else if (k < 40) host_wr(a, d);
      else if (k < 60) dev_wr(int'($urandom_range(0, PW - 1)), d);
      else if (k < 70) dev_fin(16'($urandom()), 21'($urandom()));
      else             host_chk("R9 random read", a);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule